// File: doc/BRIEF.md
# PCM Bus Time-Slot Assigner

This block moves four channels of 8-bit companded voice samples on and off a frame-synchronous serial PCM bus. Going out, it shifts each channel's parallel sample onto a serial transmit line during that channel's assigned slot and raises an output enable only while it is driving. Coming in, it gathers the eight bits of each channel's assigned receive slot and presents them as a parallel byte with a one-cycle strobe. Every direction of every channel has its own slot number. Each direction also has one bit offset that delays slot 0 behind the frame sync. Because the driver is released outside owned slots, the transmit line and the receive line can be tied together into one two-way wire.

A small register write port programs the assignments, the offsets, the number of slots per frame and the clocking mode. All programmed values sit in shadow storage and become active only at a frame-sync rising edge, so the host can rewrite them at any time without corrupting a frame in flight. In double-clock mode the clock runs at twice the bit rate and every data bit lasts two clock cycles.

Top module: `pcm_slot_mapper`

## Requirements
- R1: After reset every channel is unassigned. `txOe`, `txTake` and `rxValid` stay low through any number of frames until assignments are written.
- R2: A write at `cfgAddr` 0..3 sets the transmit assignment of channel 0..3, and 4..7 sets the receive assignment of channel 0..3. In both, `cfgWdata[8]` is the enable and `cfgWdata[7:0]` is the slot. Address 8 sets the transmit bit offset, 9 the receive bit offset, 10 the slots per frame (0 means 256), and bit 0 of address 11 selects double-clock mode.
- R3: Frame bits are numbered from 0, and bit 0 occupies the clock cycle after the rising clock edge that first samples `fsync` high. A transmit-enabled channel with slot s and transmit offset O drives frame bits O+8s to O+8s+7 with its sample MSB first. `txOe` is high exactly during those bits.
- R4: `txTake[c]` pulses for one cycle during the first clock of the first bit of channel c's transmit slot. This marks the moment its sample was taken from `txSample`.
- R5: `rxData` is sampled mid-bit: at the falling clock edge in single mode, and at the rising edge that ends the bit's first cycle in double mode. After the eighth bit of a channel's receive slot, `rxSample` byte c holds those bits MSB first, and `rxValid[c]` is high for exactly one cycle, the one after the last bit ends. `rxSample` does not change in any other cycle.
- R6: The transmit and receive offsets apply independently to their own direction.
- R7: A channel whose enable is clear, or whose slot is at or above the slots-per-frame setting, neither drives nor captures.
- R8: In double-clock mode each frame bit spans two clock cycles, so bit b occupies cycles 2b and 2b+1. `rxValid` is high in the second cycle of the slot's last bit.
- R9: Writes take effect only at the next `fsync` rising edge. A frame already in progress, including a slot that is mid-transfer, finishes on the old settings.
- R10: When several channels hold the same enabled transmit slot, the lowest-numbered channel drives it, and the others neither drive nor pulse `txTake`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock (bit clock, or twice it in double mode) |
| rstN | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame sync, rising edge starts a frame |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 4 | Register address |
| cfgWdata | input | 9 | Register write data |
| txSample | input | 32 | Outgoing samples, byte c for channel c |
| txTake | output | 4 | Per-channel pulse when its outgoing sample is taken |
| txData | output | 1 | Serial transmit data |
| txOe | output | 1 | Transmit driver enable |
| rxData | input | 1 | Serial receive data |
| rxSample | output | 32 | Received samples, byte c for channel c |
| rxValid | output | 4 | Per-channel one-cycle strobe for a new received byte |

## Verification
A register write can land while a channel is halfway through its transmit slot, so a configuration update and an active shift-out share the same cycles. The bench provokes this by writing a new transmit slot for channel 0 in the middle of that channel's own slot. It then checks bit by bit that the rest of the slot and the rest of the frame keep the old position, and that the new slot appears from the next frame sync. The lowest-channel arbitration is also exercised: two channels are given the same slot, and the bench checks that only channel 0's bits appear and that only channel 0 pulses `txTake`.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int CH_NUM = 4;
  localparam int SAMP_W = 8;
  localparam int SLOT_W = 8;
  localparam int BIT_IDX_W = $clog2(SAMP_W);
  localparam int POS_W = SLOT_W + BIT_IDX_W + 1;
  localparam int CH_IDX_W = $clog2(CH_NUM);
  localparam int CFG_AW = CH_IDX_W + 2;
  localparam int CFG_DW = SLOT_W + 1;
  localparam int ADDR_TX_OFF = 2 * CH_NUM;
  localparam int ADDR_RX_OFF = 2 * CH_NUM + 1;
  localparam int ADDR_LEN = 2 * CH_NUM + 2;
  localparam int ADDR_MODE = 2 * CH_NUM + 3;

  typedef struct packed {
    logic [CH_NUM-1:0]             txEn;
    logic [CH_NUM-1:0]             rxEn;
    logic [CH_NUM-1:0][SLOT_W-1:0] txSlot;
    logic [CH_NUM-1:0][SLOT_W-1:0] rxSlot;
    logic [SLOT_W-1:0]             txOff;
    logic [SLOT_W-1:0]             rxOff;
    logic [SLOT_W-1:0]             frameLen;
    logic                          dbl;
  } slotCfg_t;

  typedef struct packed {
    logic [CH_NUM-1:0] txSel;
    logic              txFirst;
    logic              txUpdate;
    logic              txOeNext;
    logic [CH_NUM-1:0] rxCap;
    logic              rxLast;
    logic              rxDirect;
  } ctrlStrobes_t;
endpackage

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
  import pcm_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fsync,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_DW-1:0] cfgWdata,
  output ctrlStrobes_t      strobes,
  output logic              running,
  output logic              phase,
  output logic              dblMode
);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam slotCfg_t CFG_RESET = '0;

  slotCfg_t shadow, act, cfgNext;
  logic fsyncPrev, fsyncRise;
  logic [POS_W-1:0] pos, posNext;
  logic phaseNext, runNext;
  logic [POS_W:0] txRel, rxRel;
  logic txIn, rxIn;
  logic [SLOT_W-1:0] txSlotNum, rxSlotNum;
  logic [CH_NUM-1:0] txHit, txSelV;

  function automatic logic [SLOT_W:0] slotsOf(input logic [SLOT_W-1:0] len);
    logic [SLOT_W:0] r;
    r = {1'b0, len};
    if (len == '0) r[SLOT_W] = 1'b1;
    return r;
  endfunction

  // shadow registers, host side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow <= CFG_RESET;
    end else if (cfgWe) begin
      if (cfgAddr < CFG_AW'(CH_NUM)) begin
        shadow.txEn[cfgAddr[CH_IDX_W-1:0]]   <= cfgWdata[SLOT_W];
        shadow.txSlot[cfgAddr[CH_IDX_W-1:0]] <= cfgWdata[SLOT_W-1:0];
      end else if (cfgAddr < CFG_AW'(2 * CH_NUM)) begin
        shadow.rxEn[cfgAddr[CH_IDX_W-1:0]]   <= cfgWdata[SLOT_W];
        shadow.rxSlot[cfgAddr[CH_IDX_W-1:0]] <= cfgWdata[SLOT_W-1:0];
      end else if (cfgAddr == CFG_AW'(ADDR_TX_OFF)) begin
        shadow.txOff <= cfgWdata[SLOT_W-1:0];
      end else if (cfgAddr == CFG_AW'(ADDR_RX_OFF)) begin
        shadow.rxOff <= cfgWdata[SLOT_W-1:0];
      end else if (cfgAddr == CFG_AW'(ADDR_LEN)) begin
        shadow.frameLen <= cfgWdata[SLOT_W-1:0];
      end else if (cfgAddr == CFG_AW'(ADDR_MODE)) begin
        shadow.dbl <= cfgWdata[0];
      end
    end
  end

  assign fsyncRise = fsync & ~fsyncPrev;

  // frame position for the upcoming cycle
  always_comb begin
    cfgNext = fsyncRise ? shadow : act;
    runNext = running | fsyncRise;
    if (fsyncRise) begin
      posNext   = '0;
      phaseNext = 1'b0;
    end else if (act.dbl && !phase) begin
      posNext   = pos;
      phaseNext = 1'b1;
    end else begin
      posNext   = (pos == POS_MAX) ? pos : pos + 1'b1;
      phaseNext = 1'b0;
    end
  end

  // transmit decode looks one cycle ahead so the output is registered
  always_comb begin
    txRel     = {1'b0, posNext} - (POS_W + 1)'(cfgNext.txOff);
    txIn      = !txRel[POS_W] && (txRel[POS_W-1:BIT_IDX_W] < slotsOf(cfgNext.frameLen));
    txSlotNum = txRel[BIT_IDX_W +: SLOT_W];
    for (int c = 0; c < CH_NUM; c++) begin
      txHit[c] = runNext && txIn && cfgNext.txEn[c] && (cfgNext.txSlot[c] == txSlotNum);
    end
    txSelV = '0;
    for (int c = CH_NUM - 1; c >= 0; c--) begin
      if (txHit[c]) begin
        txSelV    = '0;
        txSelV[c] = 1'b1;
      end
    end
  end

  // receive decode works on the bit that is ending now
  always_comb begin
    rxRel     = {1'b0, pos} - (POS_W + 1)'(act.rxOff);
    rxIn      = !rxRel[POS_W] && (rxRel[POS_W-1:BIT_IDX_W] < slotsOf(act.frameLen));
    rxSlotNum = rxRel[BIT_IDX_W +: SLOT_W];
    for (int c = 0; c < CH_NUM; c++) begin
      strobes.rxCap[c] = running && rxIn && (!act.dbl || !phase) &&
                         act.rxEn[c] && (act.rxSlot[c] == rxSlotNum);
    end
    strobes.rxLast   = (rxRel[BIT_IDX_W-1:0] == '1);
    strobes.rxDirect = act.dbl;
    strobes.txSel    = txSelV;
    strobes.txFirst  = (txRel[BIT_IDX_W-1:0] == '0);
    strobes.txUpdate = !(cfgNext.dbl && phaseNext);
    strobes.txOeNext = |txHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsyncPrev <= 1'b0;
      pos       <= POS_MAX;
      phase     <= 1'b0;
      running   <= 1'b0;
      act       <= CFG_RESET;
    end else begin
      fsyncPrev <= fsync;
      pos       <= posNext;
      phase     <= phaseNext;
      running   <= runNext;
      act       <= cfgNext;
    end
  end

  assign dblMode = act.dbl;
endmodule

// File: rtl/pcm_slot_data.sv
module pcm_slot_data
  import pcm_slot_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  input  logic [CH_NUM*SAMP_W-1:0] txSample,
  input  logic                     rxData,
  output logic [CH_NUM-1:0]        txTake,
  output logic                     txData,
  output logic                     txOe,
  output logic [CH_NUM*SAMP_W-1:0] rxSample,
  output logic [CH_NUM-1:0]        rxValid
);
  logic [CH_NUM-1:0][SAMP_W-1:0] txSh;
  logic [CH_NUM-1:0][SAMP_W-2:0] rxSh;
  logic rxNeg, rxBit, curBit;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) rxNeg <= 1'b0;
    else       rxNeg <= rxData;
  end

  assign rxBit = strobes.rxDirect ? rxData : rxNeg;

  always_comb begin
    curBit = 1'b0;
    for (int c = 0; c < CH_NUM; c++) begin
      if (strobes.txSel[c]) begin
        curBit = strobes.txFirst ? txSample[c*SAMP_W + SAMP_W - 1] : txSh[c][SAMP_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData   <= 1'b0;
      txOe     <= 1'b0;
      txTake   <= '0;
      txSh     <= '0;
      rxSh     <= '0;
      rxSample <= '0;
      rxValid  <= '0;
    end else begin
      if (strobes.txUpdate) begin
        txOe   <= strobes.txOeNext;
        txData <= strobes.txOeNext & curBit;
      end
      for (int c = 0; c < CH_NUM; c++) begin
        txTake[c] <= strobes.txUpdate & strobes.txSel[c] & strobes.txFirst;
        if (strobes.txUpdate && strobes.txSel[c]) begin
          txSh[c] <= strobes.txFirst ? (txSample[c*SAMP_W +: SAMP_W] << 1) : (txSh[c] << 1);
        end
        rxValid[c] <= strobes.rxCap[c] & strobes.rxLast;
        if (strobes.rxCap[c]) begin
          rxSh[c] <= {rxSh[c][SAMP_W-3:0], rxBit};
          if (strobes.rxLast) rxSample[c*SAMP_W +: SAMP_W] <= {rxSh[c], rxBit};
        end
      end
    end
  end
endmodule

// File: rtl/pcm_slot_mapper.sv
module pcm_slot_mapper
  import pcm_slot_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     fsync,
  input  logic                     cfgWe,
  input  logic [CFG_AW-1:0]        cfgAddr,
  input  logic [CFG_DW-1:0]        cfgWdata,
  input  logic [CH_NUM*SAMP_W-1:0] txSample,
  output logic [CH_NUM-1:0]        txTake,
  output logic                     txData,
  output logic                     txOe,
  input  logic                     rxData,
  output logic [CH_NUM*SAMP_W-1:0] rxSample,
  output logic [CH_NUM-1:0]        rxValid
);
  ctrlStrobes_t strobes;
  logic running, phase, dblMode;

  pcm_slot_ctrl ctrl (
    .clk(clk), .rstN(rstN), .fsync(fsync), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .strobes(strobes), .running(running), .phase(phase),
    .dblMode(dblMode)
  );

  pcm_slot_data data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txSample(txSample), .rxData(rxData),
    .txTake(txTake), .txData(txData), .txOe(txOe), .rxSample(rxSample), .rxValid(rxValid)
  );
endmodule

// File: rtl/pcm_slot_mapper_chk.sv
module pcm_slot_mapper_chk
  import pcm_slot_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     txOe,
  input logic                     txData,
  input logic [CH_NUM-1:0]        txTake,
  input logic [CH_NUM*SAMP_W-1:0] rxSample,
  input logic [CH_NUM-1:0]        rxValid,
  input logic                     running,
  input logic                     phase,
  input logic                     dblMode
);
  assert_idle_before_sync_R1: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!txOe && rxValid == '0 && txTake == '0))
    else $error("bus activity before first frame sync");

  assert_take_while_driving_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txTake != '0) |-> txOe)
    else $error("sample taken while driver released");

  assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid == '0) |-> $stable(rxSample))
    else $error("received byte changed without strobe");

  assert_double_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dblMode && phase) |-> ($stable(txData) && $stable(txOe)))
    else $error("transmit changed in second half of a bit");

  assert_single_owner_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(txTake))
    else $error("more than one channel took a sample");
endmodule

bind pcm_slot_mapper pcm_slot_mapper_chk chk (
  .clk(clk), .rstN(rstN), .txOe(txOe), .txData(txData), .txTake(txTake),
  .rxSample(rxSample), .rxValid(rxValid), .running(running), .phase(phase),
  .dblMode(dblMode)
);

// File: tb/pcm_slot_mapper_test.sv
module pcm_slot_mapper_test;
  import pcm_slot_pkg::*;

  logic clk = 1'b0, rstN = 1'b0, fsync = 1'b0, cfgWe = 1'b0, rxData = 1'b0;
  logic [CFG_AW-1:0] cfgAddr = '0;
  logic [CFG_DW-1:0] cfgWdata = '0;
  logic [CH_NUM*SAMP_W-1:0] txSample = '0;
  logic [CH_NUM-1:0] txTake, rxValid;
  logic txData, txOe;
  logic [CH_NUM*SAMP_W-1:0] rxSample;

  pcm_slot_mapper uut (
    .clk(clk), .rstN(rstN), .fsync(fsync), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .txSample(txSample), .txTake(txTake), .txData(txData),
    .txOe(txOe), .rxData(rxData), .rxSample(rxSample), .rxValid(rxValid)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic oe;
    logic data;
    logic [CH_NUM-1:0] take;
    logic [CH_NUM-1:0] valid;
    logic [CH_NUM*SAMP_W-1:0] samp;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0, errors = 0;
  string curTag = "R1";
  bit done = 1'b0;

  // pending (written) and active (in force) copies of the settings
  int pTxSlot[CH_NUM], pRxSlot[CH_NUM], aTxSlot[CH_NUM], aRxSlot[CH_NUM];
  bit pTxEn[CH_NUM], pRxEn[CH_NUM], aTxEn[CH_NUM], aRxEn[CH_NUM];
  int pTxOff = 0, pRxOff = 0, pLen = 0, aTxOff = 0, aRxOff = 0, aLen = 0;
  bit pDbl = 0, aDbl = 0;

  function automatic bit rxPat(int b);
    return ((b * 5 + b / 3) % 4) < 2;
  endfunction

  function automatic void mirrorWrite(int addr, int data);
    if (addr < CH_NUM) begin
      pTxEn[addr] = data[8]; pTxSlot[addr] = data & 255;
    end else if (addr < 2 * CH_NUM) begin
      pRxEn[addr - CH_NUM] = data[8]; pRxSlot[addr - CH_NUM] = data & 255;
    end else if (addr == 8) pTxOff = data & 255;
    else if (addr == 9) pRxOff = data & 255;
    else if (addr == 10) pLen = data & 255;
    else if (addr == 11) pDbl = data[0];
  endfunction

  function automatic void activate();
    for (int c = 0; c < CH_NUM; c++) begin
      aTxSlot[c] = pTxSlot[c]; aRxSlot[c] = pRxSlot[c];
      aTxEn[c] = pTxEn[c]; aRxEn[c] = pRxEn[c];
    end
    aTxOff = pTxOff; aRxOff = pRxOff; aLen = pLen; aDbl = pDbl;
  endfunction

  function automatic expItem_t expectAt(int k);
    expItem_t e;
    int d, b, ph, len, win, i, last;
    e = '0;
    d = aDbl ? 2 : 1;
    b = k / d;
    ph = k % d;
    len = (aLen == 0) ? 256 : aLen;
    win = -1;
    for (int c = 0; c < CH_NUM; c++) begin
      if (win < 0 && aTxEn[c] && aTxSlot[c] < len && b >= aTxOff &&
          (b - aTxOff) / 8 == aTxSlot[c]) win = c;
    end
    if (win >= 0) begin
      i = (b - aTxOff) % 8;
      e.oe = 1'b1;
      e.data = txSample[win * 8 + 7 - i];
      e.take[win] = (i == 0 && ph == 0);
    end
    for (int c = 0; c < CH_NUM; c++) begin
      if (aRxEn[c] && aRxSlot[c] < len) begin
        last = aRxOff + 8 * aRxSlot[c] + 7;
        if (k == ((d == 1) ? last + 1 : 2 * last + 1)) begin
          e.valid[c] = 1'b1;
          for (int j = 0; j < 8; j++) e.samp[c * 8 + 7 - j] = rxPat(last - 7 + j);
        end
      end
    end
    return e;
  endfunction

  task automatic cfgWrite(int addr, int data);
    @(posedge clk); #1;
    cfgWe = 1'b1; cfgAddr = CFG_AW'(addr); cfgWdata = CFG_DW'(data);
    mirrorWrite(addr, data);
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  // driver: starts a frame and pushes one expected item per cycle
  task automatic runFrame(int n, int wrK, int wrAddr, int wrData);
    @(posedge clk); #1 fsync = 1'b1;
    @(posedge clk); #1 fsync = 1'b0;
    activate();
    for (int k = 0; k < n; k++) begin
      if (k > 0) begin @(posedge clk); #1; end
      cfgWe = (k == wrK);
      if (k == wrK) begin
        cfgAddr = CFG_AW'(wrAddr); cfgWdata = CFG_DW'(wrData);
        mirrorWrite(wrAddr, wrData);
      end
      rxData = rxPat(k / (aDbl ? 2 : 1));
      expQ.push_back(expectAt(k));
    end
    @(posedge clk); #1 cfgWe = 1'b0;
    while (expQ.size() > 0) @(negedge clk);
  endtask

  // monitor: compares each cycle away from the active edge
  initial begin
    expItem_t e;
    logic [CH_NUM*SAMP_W-1:0] mask;
    bit ok;
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        mask = '0;
        for (int c = 0; c < CH_NUM; c++) if (e.valid[c]) mask[c*8 +: 8] = 8'hFF;
        ok = (txOe === e.oe) && (!e.oe || txData === e.data) && (txTake === e.take) &&
             (rxValid === e.valid) && ((rxSample & mask) === (e.samp & mask));
        checks++;
        if (!ok) begin
          errors++;
          $display("FAIL %s: got oe=%0b data=%0b take=%b valid=%b samp=%h, expected oe=%0b data=%0b take=%b valid=%b samp=%h",
                   curTag, txOe, txData, txTake, rxValid, rxSample & mask,
                   e.oe, e.data, e.take, e.valid, e.samp & mask);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < CH_NUM; c++) begin
      pTxSlot[c] = 0; pRxSlot[c] = 0; pTxEn[c] = 0; pRxEn[c] = 0;
    end
    activate();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (txOe !== 1'b0 || rxValid !== '0 || txTake !== '0) begin
      errors++;
      $display("FAIL R1: got oe=%0b valid=%b take=%b, expected all zero", txOe, rxValid, txTake);
    end

    // R1: nothing assigned, a whole frame stays idle
    curTag = "R1";
    runFrame(40, -1, 0, 0);

    txSample = {8'h96, 8'hF0, 8'h3C, 8'hA5};
    cfgWrite(10, 8);
    cfgWrite(8, 3);
    cfgWrite(9, 1);
    cfgWrite(0, 256 + 2);
    cfgWrite(1, 256 + 5);
    cfgWrite(2, 1);
    cfgWrite(3, 256 + 9);
    cfgWrite(4, 256 + 0);
    cfgWrite(5, 256 + 7);
    cfgWrite(6, 256 + 8);
    cfgWrite(7, 256 + 3);

    // R2 R3 R4 R5 R6 R7, plus an R9 write landing inside channel 0's slot
    curTag = "R2 R3 R4 R5 R6 R7 R9";
    runFrame(80, 20, 0, 256 + 6);

    // R9: the mid-frame write now in force
    curTag = "R9 R3";
    runFrame(80, -1, 0, 0);

    // R10: channels 0 and 1 share slot 6
    cfgWrite(1, 256 + 6);
    curTag = "R10";
    runFrame(80, -1, 0, 0);

    // R8: double-clock mode with new offsets and a short frame
    cfgWrite(11, 1);
    cfgWrite(10, 4);
    cfgWrite(8, 0);
    cfgWrite(9, 2);
    cfgWrite(0, 256 + 3);
    cfgWrite(1, 5);
    cfgWrite(2, 256 + 1);
    cfgWrite(4, 256 + 0);
    cfgWrite(5, 256 + 2);
    cfgWrite(6, 256 + 4);
    cfgWrite(7, 256 + 3);
    curTag = "R8 R7";
    runFrame(80, -1, 0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule